// File: doc/BRIEF.md
# Ethernet Transmit Frame Builder

This block turns a host byte stream into a complete Ethernet frame on a physical-layer byte interface. The host supplies only the frame content: a 6-byte destination address, a 6-byte source address, a 2-byte type field and the payload. Framing is done entirely in hardware, so the host never works out the preamble, the check sequence or the length rules.

For each frame the block does five things in order:

- It emits the preamble and start delimiter.
- It passes the host bytes through unchanged.
- If the content is shorter than 60 bytes, it pads with zeros up to 60.
- It appends a CRC-32 frame check sequence.
- It holds transmit enable low for the inter-frame gap before it accepts another frame.

The host must present the bytes of a frame back to back, with no bubble on `in_valid`, once the first byte has been accepted.

The controller has seven states:

| State | Behaviour | Transition |
|-------|-----------|------------|
| `ST_IDLE` | Waits for a frame. | Goes to `ST_PREAMBLE` when `in_valid` is seen. |
| `ST_PREAMBLE` | Emits the preamble bytes. | Goes to `ST_SFD` after `PRE_LEN` bytes. |
| `ST_SFD` | Emits the delimiter and seeds the CRC. | Always goes to `ST_BODY`. |
| `ST_BODY` | Accepts host bytes. | Goes to `ST_PAD` on the last byte if fewer than `MIN_BODY` bytes were taken, otherwise to `ST_FCS`. |
| `ST_PAD` | Emits zero bytes. | Goes to `ST_FCS` when the count of content and pad bytes reaches `MIN_BODY`. |
| `ST_FCS` | Emits the four check bytes. | Goes to `ST_GAP`. |
| `ST_GAP` | Keeps the line quiet. | Goes back to `ST_IDLE` after `GAP_LEN` cycles. |

Top module: `eth_tx_framer`

## Requirements
- R1: While reset is held and right after it, `phy_en` is 0 and `in_ready` is 0.
- R2: Each frame starts with `phy_en` rising, carrying seven bytes of 0x55 followed by one byte of 0xD5, before any host byte.
- R3: The host bytes appear on `phy_data` unchanged and in order, starting in the byte time right after 0xD5.
- R4: When the host supplies N < 60 bytes, the block sends 60 − N bytes of 0x00 right after the last host byte.
- R5: After the content and any pad, four check bytes follow. They are computed with CRC-32 (polynomial 0x04C11DB7, bits taken least significant first, which is the reflected constant 0xEDB88320), starting from 0xFFFFFFFF and covering every content and pad byte. The result is inverted and sent least significant byte first.
- R6: `phy_en` stays high without a break for 8 + max(N,60) + 4 byte times. The frame is therefore never shorter than 64 bytes counted from the destination address through the check sequence.
- R7: Between two frames, `phy_en` is low for at least 12 byte times.
- R8: `in_ready` is high only while host bytes are being put on the line. It is low during the preamble, delimiter, pad, check sequence and gap. A new frame's first byte is accepted no earlier than 9 cycles after `in_valid` is seen in idle.
- R9: When N ≥ 60, no pad is inserted and the check sequence follows the last host byte directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Host frame byte |
| in_valid | input | 1 | Host byte present |
| in_last | input | 1 | Marks the final host byte of the frame |
| in_ready | output | 1 | Block takes the byte this cycle |
| phy_data | output | 8 | Byte toward the physical layer |
| phy_en | output | 1 | Transmit enable, high for every frame byte |

## Verification
The bench aims at the pad boundary by sending 1, 14, 59, 60, 61 and 100 content bytes. A block with an off-by-one in its pad counter would send 59 or 61 content-plus-pad bytes, and the check-sequence bytes and the frame length would both miscompare. Check values are produced by an independent reference CRC, so a wrong seed, a missing inversion or a swapped byte order each corrupt the last four bytes of every frame. Frames are also sent back to back, which measures the idle run between them: a gap counter that exits early, or a ready that rises before the preamble, shows up as a short low run or as host bytes landing in the wrong slots.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_SFD,
        ST_BODY,
        ST_PAD,
        ST_FCS,
        ST_GAP
    } tx_state_t;

    localparam logic [7:0]  PRE_BYTE   = 8'h55;
    localparam logic [7:0]  SFD_BYTE   = 8'hD5;
    localparam logic [7:0]  PAD_BYTE   = 8'h00;
    localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED   = 32'hFFFFFFFF;
    localparam int          FCS_BYTES  = 4;

endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
    import eth_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed,
    input  logic              step,
    input  logic [DATA_W-1:0] din,
    output logic [31:0]       crc_q
);

    // One reflected shift stage per input bit, least significant bit first.
    logic [31:0] chain [DATA_W+1];

    assign chain[0] = crc_q;

    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            assign chain[b+1] = (chain[b] >> 1) ^
                                ((chain[b][0] ^ din[b]) ? CRC_POLY_R : 32'h0);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (seed) begin
            crc_q <= CRC_SEED;
        end else if (step) begin
            crc_q <= chain[DATA_W];
        end
    end

endmodule

// File: rtl/eth_tx_ctrl.sv
module eth_tx_ctrl
    import eth_tx_pkg::*;
#(
    parameter int PRE_LEN  = 7,
    parameter int MIN_BODY = 60,
    parameter int GAP_LEN  = 12
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  logic      in_last,
    output tx_state_t st,
    output logic [1:0] fcs_idx,
    output logic      in_ready,
    output logic      take,
    output logic      crc_seed,
    output logic      crc_step
);

    localparam int CNT_MAX0 = (PRE_LEN > GAP_LEN) ? PRE_LEN : GAP_LEN;
    localparam int CNT_MAX  = (CNT_MAX0 > FCS_BYTES) ? CNT_MAX0 : FCS_BYTES;
    localparam int CNT_W    = $clog2(CNT_MAX) + 1;
    localparam int BODY_W   = $clog2(MIN_BODY + 1);

    tx_state_t         st_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [BODY_W-1:0] body_cnt, body_n;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            body_cnt <= '0;
        end else begin
            st       <= st_n;
            cnt      <= cnt_n;
            body_cnt <= body_n;
        end
    end

    // Next-state logic
    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        body_n = body_cnt;
        unique case (st)
            ST_IDLE: begin
                if (in_valid) begin
                    st_n  = ST_PREAMBLE;
                    cnt_n = '0;
                end
            end
            ST_PREAMBLE: begin
                if (cnt == CNT_W'(PRE_LEN - 1)) begin
                    st_n  = ST_SFD;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt + CNT_W'(1);
                end
            end
            ST_SFD: begin
                st_n   = ST_BODY;
                body_n = '0;
            end
            ST_BODY: begin
                if (in_valid) begin
                    if (body_cnt != BODY_W'(MIN_BODY)) begin
                        body_n = body_cnt + BODY_W'(1);
                    end
                    if (in_last) begin
                        cnt_n = '0;
                        st_n  = (body_cnt < BODY_W'(MIN_BODY - 1)) ? ST_PAD : ST_FCS;
                    end
                end
            end
            ST_PAD: begin
                body_n = body_cnt + BODY_W'(1);
                if (body_cnt == BODY_W'(MIN_BODY - 1)) begin
                    st_n  = ST_FCS;
                    cnt_n = '0;
                end
            end
            ST_FCS: begin
                if (cnt == CNT_W'(FCS_BYTES - 1)) begin
                    st_n  = ST_GAP;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt + CNT_W'(1);
                end
            end
            ST_GAP: begin
                if (cnt == CNT_W'(GAP_LEN - 1)) begin
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt + CNT_W'(1);
                end
            end
            default: begin
                st_n  = ST_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        in_ready = (st == ST_BODY);
        take     = (st == ST_BODY) && in_valid;
        crc_seed = (st == ST_SFD);
        crc_step = ((st == ST_BODY) && in_valid) || (st == ST_PAD);
        fcs_idx  = cnt[1:0];
    end

    // R4: padding never runs past the minimum content size
    a_r4_pad_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAD) |-> (body_cnt < BODY_W'(MIN_BODY)));

    // R8: the last accepted byte closes the acceptance window
    a_r8_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BODY && in_valid && in_last) |=> (st == ST_PAD || st == ST_FCS));

    // R9: a long frame goes straight to the check sequence
    a_r9_no_pad_long: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BODY && in_valid && in_last && body_cnt >= BODY_W'(MIN_BODY - 1))
        |=> (st == ST_FCS));

endmodule

// File: rtl/eth_tx_out.sv
module eth_tx_out
    import eth_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  tx_state_t  st,
    input  logic       take,
    input  logic [1:0] fcs_idx,
    input  logic [7:0] in_data,
    input  logic [31:0] crc_q,
    output logic [7:0] phy_data,
    output logic       phy_en
);

    logic [7:0]  sel_data;
    logic        sel_en;
    logic [31:0] crc_inv;

    assign crc_inv = ~crc_q;

    always_comb begin
        sel_data = 8'h00;
        sel_en   = 1'b0;
        unique case (st)
            ST_PREAMBLE: begin
                sel_data = PRE_BYTE;
                sel_en   = 1'b1;
            end
            ST_SFD: begin
                sel_data = SFD_BYTE;
                sel_en   = 1'b1;
            end
            ST_BODY: begin
                sel_data = in_data;
                sel_en   = take;
            end
            ST_PAD: begin
                sel_data = PAD_BYTE;
                sel_en   = 1'b1;
            end
            ST_FCS: begin
                unique case (fcs_idx)
                    2'd0: sel_data = crc_inv[7:0];
                    2'd1: sel_data = crc_inv[15:8];
                    2'd2: sel_data = crc_inv[23:16];
                    default: sel_data = crc_inv[31:24];
                endcase
                sel_en = 1'b1;
            end
            default: begin
                sel_data = 8'h00;
                sel_en   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_data <= 8'h00;
            phy_en   <= 1'b0;
        end else begin
            phy_data <= sel_data;
            phy_en   <= sel_en;
        end
    end

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
    import eth_tx_pkg::*;
#(
    parameter int PRE_LEN  = 7,
    parameter int MIN_BODY = 60,
    parameter int GAP_LEN  = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    output logic [7:0] phy_data,
    output logic       phy_en
);

    localparam int MIN_WIRE = PRE_LEN + 1 + MIN_BODY + FCS_BYTES;
    localparam int GAP_W    = $clog2(GAP_LEN + 1);
    localparam int LEN_W    = 16;

    tx_state_t   st;
    logic [1:0]  fcs_idx;
    logic        take, crc_seed, crc_step;
    logic [31:0] crc_q;
    logic [7:0]  crc_din;

    assign crc_din = (st == ST_BODY) ? in_data : PAD_BYTE;

    eth_tx_ctrl #(
        .PRE_LEN (PRE_LEN),
        .MIN_BODY(MIN_BODY),
        .GAP_LEN (GAP_LEN)
    ) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_last (in_last),
        .st      (st),
        .fcs_idx (fcs_idx),
        .in_ready(in_ready),
        .take    (take),
        .crc_seed(crc_seed),
        .crc_step(crc_step)
    );

    eth_tx_crc #(.DATA_W(8)) crc_i (
        .clk  (clk),
        .rst_n(rst_n),
        .seed (crc_seed),
        .step (crc_step),
        .din  (crc_din),
        .crc_q(crc_q)
    );

    eth_tx_out out_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .st      (st),
        .take    (take),
        .fcs_idx (fcs_idx),
        .in_data (in_data),
        .crc_q   (crc_q),
        .phy_data(phy_data),
        .phy_en  (phy_en)
    );

    // Line observers used only by the assertions below.
    logic [GAP_W-1:0] quiet_run;
    logic [LEN_W-1:0] wire_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_run <= GAP_W'(GAP_LEN);
            wire_len  <= '0;
        end else begin
            if (phy_en) begin
                quiet_run <= '0;
            end else if (quiet_run != GAP_W'(GAP_LEN)) begin
                quiet_run <= quiet_run + GAP_W'(1);
            end
            if (phy_en) begin
                if (wire_len != {LEN_W{1'b1}}) begin
                    wire_len <= wire_len + LEN_W'(1);
                end
            end else begin
                wire_len <= '0;
            end
        end
    end

    // R7: enough quiet byte times precede each frame
    a_r7_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_en) |-> (quiet_run >= GAP_W'(GAP_LEN)));

    // R2: a frame opens with a preamble byte
    a_r2_opens_preamble: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_en) |-> (phy_data == PRE_BYTE));

    // R6: a finished frame is never shorter than the minimum on the wire
    a_r6_min_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_en) |-> (wire_len >= LEN_W'(MIN_WIRE)));

    // R8: ready never opens while the line is quiet
    a_r8_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> phy_en);

endmodule

// File: tb/eth_tx_framer_tb_top.sv
module eth_tx_framer_tb_top;

    localparam int PRE  = 7;
    localparam int MINB = 60;
    localparam int GAP  = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic [7:0] phy_data;
    logic       phy_en;

    always #5 clk = ~clk;

    eth_tx_framer #(.PRE_LEN(PRE), .MIN_BODY(MINB), .GAP_LEN(GAP)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_data (in_data),
        .in_valid(in_valid),
        .in_last (in_last),
        .in_ready(in_ready),
        .phy_data(phy_data),
        .phy_en  (phy_en)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] exp_q[$];
    int         tag_q[$];
    int         len_q[$];

    function automatic logic [31:0] ref_fcs(input logic [7:0] bytes[$]);
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (bytes[i]) begin
            for (int k = 0; k < 8; k++) begin
                if (c[0] ^ bytes[i][k]) c = (c >> 1) ^ 32'hEDB88320;
                else                    c = c >> 1;
            end
        end
        return ~c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Driver: builds the expected wire image, then feeds the host bytes.
    task automatic send_frame(input int n, input int seed);
        logic [7:0] content[$];
        logic [31:0] fcs;
        int stall = 0;
        for (int i = 0; i < n; i++) content.push_back(8'(seed * 7 + i * 13 + (i >> 3)));
        for (int i = 0; i < PRE; i++) begin exp_q.push_back(8'h55); tag_q.push_back(2); end // R2
        exp_q.push_back(8'hD5); tag_q.push_back(2);                                          // R2
        for (int i = 0; i < n; i++) begin exp_q.push_back(content[i]); tag_q.push_back(3); end // R3
        begin
            logic [7:0] covered[$];
            covered = content;
            for (int i = n; i < MINB; i++) begin
                covered.push_back(8'h00);
                exp_q.push_back(8'h00); tag_q.push_back(4);                                   // R4
            end
            fcs = ref_fcs(covered);
        end
        for (int i = 0; i < 4; i++) begin exp_q.push_back(fcs[8*i +: 8]); tag_q.push_back(5); end // R5
        len_q.push_back(PRE + 1 + ((n > MINB) ? n : MINB) + 4);                               // R6, R9
        for (int i = 0; i < n; i++) begin
            in_data  = content[i];
            in_valid = 1'b1;
            in_last  = (i == n - 1);
            while (!in_ready) begin stall++; @(negedge clk); end
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        // R8: ready held low through preamble and delimiter
        check(stall >= PRE + 2, "R8 ready wait", stall, PRE + 2);
    endtask

    // Monitor: pops the scoreboard as bytes appear on the line.
    bit prev_en = 0;
    bit seen    = 0;
    int low_run = 0;
    int flen    = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (in_ready) check(phy_en, "R8 ready outside frame", 0, 1);
            if (phy_en) begin
                if (!prev_en && seen) check(low_run >= GAP, "R7 gap", low_run, GAP);
                if (exp_q.size() == 0) begin
                    check(0, "R3 unexpected byte", phy_data, 0);
                end else begin
                    logic [7:0] e;
                    int t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(phy_data == e, $sformatf("R%0d byte %0d", t, flen), phy_data, e);
                end
                flen++;
                low_run = 0;
            end else begin
                if (prev_en) begin
                    int el;
                    el = (len_q.size() != 0) ? len_q.pop_front() : -1;
                    check(flen == el, "R6 frame length", flen, el);
                    check(flen >= PRE + 1 + 64, "R6 minimum", flen, PRE + 1 + 64);
                    seen = 1;
                end
                flen = 0;
                low_run++;
            end
            prev_en = phy_en;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(phy_en == 1'b0, "R1 phy_en", phy_en, 0);
        check(in_ready == 1'b0, "R1 in_ready", in_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(phy_en == 1'b0 && in_ready == 1'b0, "R1 after release", {phy_en, in_ready}, 0);
        send_frame(14, 1);   // R4 header only, long pad
        repeat (30) @(negedge clk);
        send_frame(59, 2);   // R4 single pad byte
        send_frame(60, 3);   // R9 exact minimum, back to back
        send_frame(61, 4);   // R9
        send_frame(1, 5);    // R4
        repeat (5) @(negedge clk);
        send_frame(100, 6);  // R9 long frame
        send_frame(20, 7);
        repeat (200) @(negedge clk);
        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
        check(len_q.size() == 0, "R6 all frames ended", len_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule